// File: doc/BRIEF.md
# Per-Bit First-Fault Step Recorder

This block runs a path-delay characterisation series against a target whose 128-bit output register is sampled under a shortened clock. Each run uses the same plaintext and key. The block issues a step index, and the glitch generator converts that index into how far the final-round clock period is shortened. Each run shortens the period by one more step than the run before. When the target answers, its output word is XORed with the known correct word. Every bit that mismatches for the first time takes the current step index as its measured delay.

Each bit's entry holds a reserved unset code until its first fault. After that, later faults never change it. If the target stops answering, the glitch has upset its control logic. When a response timeout expires, every bit still unset is marked as a ghost bit and the series stops. Results are read one bit at a time through an address port.

Top module: `fault_step_recorder`

## Requirements
- R1: After reset the block is idle: `runLaunch`, `busy`, `seriesDone` and `aborted` are 0. Every bit reads the unset code (all ones on `rdStep`) with `rdGhost` at 0.
- R2: A `startSeries` pulse while idle or finished does three things: it resets every entry to unset, clears all ghost flags and clears `aborted`. The next cycle raises `runLaunch` with `stepCmd` equal to 0.
- R3: `runLaunch` is high for exactly one cycle per run. After an accepted response that does not end the series, the next cycle launches a run whose `stepCmd` is one higher than the previous run.
- R4: On an accepted response, every bit that differs between `respWord` and `refWord` and is still unset stores the current `stepCmd`. Several bits may take the same step in one run.
- R5: An entry that already holds a step keeps it, whatever later responses return for that bit.
- R6: When an accepted response leaves every bit holding a step, the series ends: `seriesDone` goes high and `busy` goes low.
- R7: The series also ends after the response to step MAX_STEP-1 is accepted. Bits that never faulted stay unset and are not ghost.
- R8: If no response arrives within TIMEOUT cycles after the launch cycle, every still-unset bit becomes a ghost bit and the series ends with `aborted` high. A ghost bit reads the unset code with `rdGhost` at 1.
- R9: A response that arrives in the last cycle of the timeout window is accepted as a normal response, and no abort takes place.
- R10: `respValid` outside a run has no effect. So does `startSeries` during a run.
- R11: `rdStep` and `rdGhost` show the entry at the `rdAddr` of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startSeries | input | 1 | Begin a new measurement series |
| refWord | input | 128 | Known correct output word |
| runLaunch | output | 1 | One-cycle pulse that launches a run |
| stepCmd | output | 8 | Step index for the current run |
| respValid | input | 1 | Target response strobe |
| respWord | input | 128 | Output word returned by the target |
| busy | output | 1 | Series in progress |
| seriesDone | output | 1 | Series has ended |
| aborted | output | 1 | Series ended by response timeout |
| rdAddr | input | 7 | Bit index to read |
| rdStep | output | 8 | Recorded step of the addressed bit (unset = all ones) |
| rdGhost | output | 1 | Ghost flag of the addressed bit |

## Verification
A response and the timeout expiry can coincide in one cycle. The bench provokes this by delaying one response to exactly the last cycle of the timeout window. It then checks that the run counts as answered: `aborted` stays low, no bit is marked ghost, and the series carries on to the next step. Capture and read-out can also overlap, because the read port samples the entry array in the same cycle a response writes it. A per-cycle reference model compares `rdStep` on every clock while reads continue through the responses.

// File: rtl/frec_pkg.sv
package frec_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LAUNCH, PH_WAIT, PH_FINISH} phase_t;

  typedef struct packed {
    logic clearAll;
    logic capture;
    logic markGhost;
  } dpStrobe_t;
endpackage

// File: rtl/frec_ctrl.sv
module frec_ctrl
  import frec_pkg::*;
#(
  parameter int STEP_W   = 8,
  parameter int MAX_STEP = 200,
  parameter int TIMEOUT  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startSeries,
  input  logic              respValid,
  input  logic              allSetNext,
  output dpStrobe_t         strobe,
  output logic              runLaunch,
  output logic [STEP_W-1:0] stepCmd,
  output logic              busy,
  output logic              seriesDone,
  output logic              aborted
);
  localparam int TMR_W = $clog2(TIMEOUT + 1);
  localparam logic [TMR_W-1:0]  TMR_LAST  = TMR_W'(TIMEOUT - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(MAX_STEP - 1);

  phase_t            phase;
  logic [TMR_W-1:0]  waitCnt;
  logic              startOk;
  logic              expire;
  logic              lastRun;

  assign startOk = (phase == PH_IDLE || phase == PH_FINISH) && startSeries;
  assign expire  = (phase == PH_WAIT) && !respValid && (waitCnt == TMR_LAST);
  assign lastRun = allSetNext || (stepCmd == STEP_LAST);

  always_comb begin
    strobe.clearAll  = startOk;
    strobe.capture   = (phase == PH_WAIT) && respValid;
    strobe.markGhost = expire;
  end

  assign runLaunch  = (phase == PH_LAUNCH);
  assign busy       = (phase == PH_LAUNCH) || (phase == PH_WAIT);
  assign seriesDone = (phase == PH_FINISH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      stepCmd <= '0;
      waitCnt <= '0;
      aborted <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE, PH_FINISH: begin
          if (startSeries) begin
            phase   <= PH_LAUNCH;
            stepCmd <= '0;
            aborted <= 1'b0;
          end
        end
        PH_LAUNCH: begin
          waitCnt <= '0;
          phase   <= PH_WAIT;
        end
        PH_WAIT: begin
          if (respValid) begin
            if (lastRun) begin
              phase <= PH_FINISH;
            end else begin
              stepCmd <= stepCmd + 1'b1;
              phase   <= PH_LAUNCH;
            end
          end else if (expire) begin
            phase   <= PH_FINISH;
            aborted <= 1'b1;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frec_datapath.sv
module frec_datapath
  import frec_pkg::*;
#(
  parameter int WIDTH  = 128,
  parameter int STEP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  dpStrobe_t                strobe,
  input  logic [STEP_W-1:0]        stepCmd,
  input  logic [WIDTH-1:0]         refWord,
  input  logic [WIDTH-1:0]         respWord,
  input  logic [$clog2(WIDTH)-1:0] rdAddr,
  output logic                     allSetNext,
  output logic [STEP_W-1:0]        rdStep,
  output logic                     rdGhost
);
  localparam logic [STEP_W-1:0] UNSET = '1;

  logic [STEP_W-1:0] entryArr [WIDTH];
  logic [WIDTH-1:0]  setMask;
  logic [WIDTH-1:0]  ghostMask;
  logic [WIDTH-1:0]  faultMask;

  assign faultMask  = (refWord ^ respWord) & ~setMask;
  assign allSetNext = &(setMask | faultMask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIDTH; i++) entryArr[i] <= UNSET;
      setMask   <= '0;
      ghostMask <= '0;
      rdStep    <= UNSET;
      rdGhost   <= 1'b0;
    end else begin
      rdStep  <= entryArr[rdAddr];
      rdGhost <= ghostMask[rdAddr];
      if (strobe.clearAll) begin
        for (int i = 0; i < WIDTH; i++) entryArr[i] <= UNSET;
        setMask   <= '0;
        ghostMask <= '0;
      end else begin
        if (strobe.capture) begin
          for (int i = 0; i < WIDTH; i++)
            if (faultMask[i]) entryArr[i] <= stepCmd;
          setMask <= setMask | faultMask;
        end
        if (strobe.markGhost) ghostMask <= ghostMask | ~setMask;
      end
    end
  end
endmodule

// File: rtl/fault_step_recorder.sv
module fault_step_recorder
  import frec_pkg::*;
#(
  parameter int WIDTH    = 128,
  parameter int STEP_W   = 8,
  parameter int MAX_STEP = 200,
  parameter int TIMEOUT  = 64,
  localparam int ADDR_W  = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startSeries,
  input  logic [WIDTH-1:0]  refWord,
  output logic              runLaunch,
  output logic [STEP_W-1:0] stepCmd,
  input  logic              respValid,
  input  logic [WIDTH-1:0]  respWord,
  output logic              busy,
  output logic              seriesDone,
  output logic              aborted,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [STEP_W-1:0] rdStep,
  output logic              rdGhost
);
  dpStrobe_t strobe;
  logic      allSetNext;

  frec_ctrl #(.STEP_W(STEP_W), .MAX_STEP(MAX_STEP), .TIMEOUT(TIMEOUT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startSeries(startSeries), .respValid(respValid),
    .allSetNext(allSetNext), .strobe(strobe), .runLaunch(runLaunch),
    .stepCmd(stepCmd), .busy(busy), .seriesDone(seriesDone), .aborted(aborted)
  );

  frec_datapath #(.WIDTH(WIDTH), .STEP_W(STEP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .stepCmd(stepCmd),
    .refWord(refWord), .respWord(respWord), .rdAddr(rdAddr),
    .allSetNext(allSetNext), .rdStep(rdStep), .rdGhost(rdGhost)
  );
endmodule

// File: rtl/frec_checker.sv
module frec_checker #(
  parameter int STEP_W   = 8,
  parameter int MAX_STEP = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              runLaunch,
  input logic [STEP_W-1:0] stepCmd,
  input logic              busy,
  input logic              seriesDone,
  input logic              aborted,
  input logic [STEP_W-1:0] rdStep,
  input logic              rdGhost
);
  AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    runLaunch |=> !runLaunch); // R3
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    runLaunch && $past(busy) |-> stepCmd == $past(stepCmd) + 1'b1); // R3
  AST_FIRST_STEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    runLaunch && !$past(busy) |-> stepCmd == '0); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seriesDone |-> !busy); // R6
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> stepCmd < STEP_W'(MAX_STEP)); // R7
  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> seriesDone); // R8
  AST_GHOST_UNSET: assert property (@(posedge clk) disable iff (!rst_n)
    rdGhost |-> rdStep == '1); // R8
endmodule

bind fault_step_recorder frec_checker #(.STEP_W(STEP_W), .MAX_STEP(MAX_STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .runLaunch(runLaunch), .stepCmd(stepCmd), .busy(busy),
  .seriesDone(seriesDone), .aborted(aborted), .rdStep(rdStep), .rdGhost(rdGhost)
);

// File: tb/fault_step_recorder_tb.sv
`timescale 1ns/1ps
module fault_step_recorder_tb;
  localparam int WIDTH = 128, STEP_W = 8, MAX_STEP = 60, TIMEOUT = 16;
  localparam int UNSET = 255;

  logic clk = 0, rst_n = 0, startSeries = 0, respValid = 0;
  logic [WIDTH-1:0] refWord = {32'hA5C3_1E07, 32'h0F1E_2D3C, 32'h9B8A_7766, 32'h1234_FEDC};
  logic [WIDTH-1:0] respWord = '0;
  logic [6:0] rdAddr = 0;
  logic runLaunch, busy, seriesDone, aborted, rdGhost;
  logic [STEP_W-1:0] stepCmd, rdStep;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fault_step_recorder #(.WIDTH(WIDTH), .STEP_W(STEP_W), .MAX_STEP(MAX_STEP), .TIMEOUT(TIMEOUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .startSeries(startSeries), .refWord(refWord),
    .runLaunch(runLaunch), .stepCmd(stepCmd), .respValid(respValid), .respWord(respWord),
    .busy(busy), .seriesDone(seriesDone), .aborted(aborted), .rdAddr(rdAddr),
    .rdStep(rdStep), .rdGhost(rdGhost));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated at each rising edge
  int mPhase = 0, mStep = 0, mTimer = 0, mAbort = 0, mRdStep = UNSET, mRdGhost = 0;
  int mEntry[WIDTH];
  bit mGhost[WIDTH];
  bit mValid = 0;

  always @(posedge clk) begin
    int nRd, nRg;
    bit allSet;
    mValid = 1;
    if (!rst_n) begin
      mPhase = 0; mStep = 0; mTimer = 0; mAbort = 0; mRdStep = UNSET; mRdGhost = 0;
      foreach (mEntry[b]) begin mEntry[b] = UNSET; mGhost[b] = 0; end
    end else begin
      nRd = mEntry[rdAddr]; nRg = mGhost[rdAddr];
      if (mPhase == 0 || mPhase == 3) begin
        if (startSeries) begin
          foreach (mEntry[b]) begin mEntry[b] = UNSET; mGhost[b] = 0; end
          mPhase = 1; mStep = 0; mAbort = 0;
        end
      end else if (mPhase == 1) begin
        mTimer = 0; mPhase = 2;
      end else begin
        if (respValid) begin
          allSet = 1;
          for (int b = 0; b < WIDTH; b++) begin
            if (refWord[b] != respWord[b] && mEntry[b] == UNSET) mEntry[b] = mStep;
            if (mEntry[b] == UNSET) allSet = 0;
          end
          if (allSet || mStep == MAX_STEP - 1) mPhase = 3;
          else begin mStep++; mPhase = 1; end
        end else if (mTimer == TIMEOUT - 1) begin
          for (int b = 0; b < WIDTH; b++) if (mEntry[b] == UNSET) mGhost[b] = 1;
          mAbort = 1; mPhase = 3;
        end else mTimer++;
      end
      mRdStep = nRd; mRdGhost = nRg;
    end
  end

  always @(negedge clk) if (mValid) begin
    chk("R3 runLaunch", runLaunch, mPhase == 1);
    chk("R2 R3 stepCmd", stepCmd, mStep);
    chk("R10 busy", busy, mPhase == 1 || mPhase == 2);
    chk("R6 seriesDone", seriesDone, mPhase == 3);
    chk("R8 aborted", aborted, mAbort);
    chk("R4 R11 rdStep", rdStep, mRdStep);
    chk("R8 R11 rdGhost", rdGhost, mRdGhost);
  end

  function automatic int thr(input int b);
    return (b * 37) % 45;
  endfunction

  function automatic logic [WIDTH-1:0] pat(input int kind, input int s);
    logic [WIDTH-1:0] m = '0;
    for (int b = 0; b < WIDTH; b++)
      if (s >= thr(b) && ((s - thr(b)) % 2 == 0) && !(kind == 1 && b >= 64)) m[b] = 1'b1;
    return m;
  endfunction

  task automatic startRun();
    @(negedge clk); startSeries = 1;
    @(negedge clk); startSeries = 0;
  endtask

  // Emulated target: kind 2 stops answering at step 5, kind 3 answers step 2 at the last timeout cycle
  task automatic serve(input int kind);
    int s, d;
    while (!seriesDone) begin
      if (runLaunch) begin
        s = stepCmd;
        if (kind == 2 && s == 5) begin @(negedge clk); continue; end
        d = (kind == 3 && s == 2) ? TIMEOUT : 1 + (s % 3);
        repeat (d) @(negedge clk);
        if (kind == 3 && s == 1) startSeries = 1;   // R10: start during a run
        respValid = 1; respWord = refWord ^ pat(kind, s);
        @(negedge clk);
        respValid = 0; startSeries = 0;
      end else @(negedge clk);
    end
  endtask

  task automatic readChk(input int a, input int expStep, input int expGhost, input string tag);
    @(negedge clk); rdAddr = 7'(a);
    @(negedge clk);
    chk(tag, rdStep, expStep);
    chk(tag, rdGhost, expGhost);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 busy", busy, 0); chk("R1 done", seriesDone, 0); chk("R1 aborted", aborted, 0);
    readChk(5, UNSET, 0, "R1 entry");
    readChk(127, UNSET, 0, "R1 entry");

    // Series A: faults spread over steps, set bits toggle later (R4, R5, R6)
    startRun(); serve(0);
    chk("R6 done", seriesDone, 1); chk("R6 step", stepCmd, 44);
    @(negedge clk); respValid = 1; respWord = ~refWord;  // R10: stray response
    @(negedge clk); respValid = 0;
    for (int b = 0; b < WIDTH; b++) readChk(b, thr(b), 0, "R4 R5 R10 entry");

    // Series B: upper half never faults, ends at last step (R7)
    startRun(); serve(1);
    chk("R7 step", stepCmd, MAX_STEP - 1); chk("R7 aborted", aborted, 0);
    for (int b = 60; b < 70; b++) readChk(b, b < 64 ? thr(b) : UNSET, 0, "R7 entry");

    // Series C: target goes silent at step 5 (R8)
    startRun(); serve(2);
    chk("R8 aborted", aborted, 1); chk("R8 step", stepCmd, 5);
    for (int b = 0; b < 20; b++)
      readChk(b, thr(b) < 5 ? thr(b) : UNSET, thr(b) < 5 ? 0 : 1, "R8 entry");

    // Series D: response at the last timeout cycle (R9) and a start during a run (R10)
    startRun(); serve(3);
    chk("R9 aborted", aborted, 0); chk("R9 done", seriesDone, 1);
    for (int b = 0; b < 10; b++) readChk(b, thr(b), 0, "R9 entry");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule